// File: doc/BRIEF.md
# Write Buffer With L2 Way-Tag Side Buffer

This block queues stores issued by a write-through L1 data cache and hands them to the L2 cache one at a time, oldest first, so the core never waits for an L2 write to finish. Next to every queued store it keeps a small side record: the 2-bit L2 way the line was found in when L1 filled it, and a flag saying whether the store hit in L1. When an entry is offered to L2, a way decoder turns that record into four L2 way-enable lines. A store that hit in L1 wakes only its own way. A store that missed in L1 wakes all four ways.

L1 read misses share the L2-side port through a bypass. A pending read miss is presented ahead of any queued store, always with all four ways enabled. The read miss is not stored: the requester holds it until L2 accepts it.

Occupancy is tracked by a three-state machine. `OCC_EMPTY` moves to `OCC_PARTIAL` on an accepted push. `OCC_PARTIAL` moves to `OCC_FULL` when the count reaches the depth, and back to `OCC_EMPTY` when the last entry drains. `OCC_FULL` returns to `OCC_PARTIAL` on a drain. With a depth of one, `OCC_EMPTY` and `OCC_FULL` move directly into each other.

Top module: `wtag_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `l2_valid_o` is 0 and `stall_o` is 0 while no request is driven.
- R2: Buffered stores are offered on the L2 port strictly in the order they were accepted.
- R3: A push while `DEPTH` entries are held raises `stall_o` in that same cycle. The store is not accepted and never appears on the L2 port.
- R4: Each entry keeps its own way tag and L1-hit flag, in a side buffer of the same depth that moves with the entry.
- R5: For an entry pushed with the hit flag at 1, `l2_way_en_o` is one-hot. Way code k (0 to 3) drives bit k.
- R6: For an entry pushed with the hit flag at 0, `l2_way_en_o` is 4'b1111.
- R7: While `rdmiss_valid_i` is 1, the L2 port shows the read-miss address with `l2_write_o` at 0 and `l2_way_en_o` at 4'b1111.
- R8: A read miss takes priority over a buffered store in the same cycle. The buffered store is not consumed in that cycle.
- R9: A buffered store leaves the buffer only in a cycle in which `l2_valid_o` and `l2_ready_i` are both 1 for that store.
- R10: In a cycle with both a push accepted and a store drained, the occupancy stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | L1 store request |
| push_addr_i | input | AW | Store address |
| push_data_i | input | DW | Store data |
| push_way_i | input | WAY_W | L2 way tag of the line (2 bits by default) |
| push_hit_i | input | 1 | 1 when the store hit in L1 |
| stall_o | output | 1 | Push refused because the buffer is full |
| rdmiss_valid_i | input | 1 | L1 read miss pending |
| rdmiss_addr_i | input | AW | Read-miss address |
| l2_valid_o | output | 1 | L2 request valid |
| l2_ready_i | input | 1 | L2 accepts the request |
| l2_write_o | output | 1 | 1 for a store, 0 for a read miss |
| l2_addr_o | output | AW | L2 request address |
| l2_data_o | output | DW | L2 store data |
| l2_way_en_o | output | WAYS | L2 way enables |

## Verification
The assertions assume that `push_way_i` is always a legal way code below `WAYS`. The bench draws way tags only from that range. They also assume that a read miss stays asserted until L2 takes it. The bench holds each random read miss until it sees ready. Around the random traffic, directed phases fill the buffer with ready held low, push into a full buffer, and hold a read miss against a non-empty queue.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/wtb_ctrl.sv
module wtb_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_req,
    input  logic                     pop_req,
    output logic                     push_ok,
    output logic                     pop_ok,
    output logic                     is_empty,
    output logic [PTR_W-1:0]         wr_ptr,
    output logic [PTR_W-1:0]         rd_ptr,
    output logic [CNT_W-1:0]         count,
    output wtb_pkg::occ_state_e      state
);
    import wtb_pkg::*;

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] wr_q, rd_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Outputs and next-state
    always_comb begin
        is_empty = (state_q == OCC_EMPTY);
        push_ok  = push_req && (state_q != OCC_FULL);
        pop_ok   = pop_req && !is_empty;
        cnt_d    = cnt_q;
        if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
        if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY:   if (push_ok) state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
            OCC_PARTIAL: begin
                if (cnt_d == CNT_W'(DEPTH)) state_d = OCC_FULL;
                else if (cnt_d == '0)       state_d = OCC_EMPTY;
            end
            OCC_FULL:    if (pop_ok) state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
            default:     state_d = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (push_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
        end
    end

    assign wr_ptr = wr_q;
    assign rd_ptr = rd_q;
    assign count  = cnt_q;
    assign state  = state_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    assert_full_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL && push_req && !pop_req) |=> (cnt_q == $past(cnt_q)));
    assert_balanced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/wtb_store.sv
module wtb_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WAY_W = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [AW-1:0]    in_addr,
    input  logic [DW-1:0]    in_data,
    input  logic [WAY_W-1:0] in_way,
    input  logic             in_hit,
    output logic [AW-1:0]    out_addr,
    output logic [DW-1:0]    out_data,
    output logic [WAY_W-1:0] out_way,
    output logic             out_hit
);
    logic [AW-1:0]    addr_mem [DEPTH];
    logic [DW-1:0]    data_mem [DEPTH];
    // way-tag side buffer, same depth and pointers as the main store
    logic [WAY_W-1:0] way_mem  [DEPTH];
    logic             hit_mem  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(e)) begin
                addr_mem[e] <= in_addr;
                data_mem[e] <= in_data;
                way_mem[e]  <= in_way;
                hit_mem[e]  <= in_hit;
            end
        end
    end

    assign out_addr = addr_mem[rd_ptr];
    assign out_data = data_mem[rd_ptr];
    assign out_way  = way_mem[rd_ptr];
    assign out_hit  = hit_mem[rd_ptr];
endmodule

// File: rtl/wtb_way_decoder.sv
module wtb_way_decoder #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             force_all,
    input  logic             l1_hit,
    input  logic [WAY_W-1:0] way,
    output logic [WAYS-1:0]  way_en
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_en[w] = force_all || !l1_hit || (way == WAY_W'(w));
    end

    always_comb begin
        if (!force_all && l1_hit && 32'(way) < WAYS)
            assert_single_way_R5: assert ($onehot(way_en));
    end
endmodule

// File: rtl/wtag_write_buffer.sv
module wtag_write_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid_i,
    input  logic [AW-1:0]    push_addr_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic [WAY_W-1:0] push_way_i,
    input  logic             push_hit_i,
    output logic             stall_o,
    input  logic             rdmiss_valid_i,
    input  logic [AW-1:0]    rdmiss_addr_i,
    output logic             l2_valid_o,
    input  logic             l2_ready_i,
    output logic             l2_write_o,
    output logic [AW-1:0]    l2_addr_o,
    output logic [DW-1:0]    l2_data_o,
    output logic [WAYS-1:0]  l2_way_en_o
);
    import wtb_pkg::*;

    logic             push_ok, pop_ok, is_empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    occ_state_e       state;
    logic [AW-1:0]    head_addr;
    logic [DW-1:0]    head_data;
    logic [WAY_W-1:0] head_way;
    logic             head_hit;

    wtb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_valid_i),
        .pop_req(l2_ready_i && !rdmiss_valid_i),
        .push_ok(push_ok), .pop_ok(pop_ok), .is_empty(is_empty),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .state(state)
    );

    wtb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .WAY_W(WAY_W)) u_store (
        .clk(clk), .wr_en(push_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .in_addr(push_addr_i), .in_data(push_data_i),
        .in_way(push_way_i), .in_hit(push_hit_i),
        .out_addr(head_addr), .out_data(head_data),
        .out_way(head_way), .out_hit(head_hit)
    );

    wtb_way_decoder #(.WAYS(WAYS)) u_dec (
        .force_all(rdmiss_valid_i), .l1_hit(head_hit),
        .way(head_way), .way_en(l2_way_en_o)
    );

    assign stall_o    = push_valid_i && (state == OCC_FULL);
    assign l2_valid_o = rdmiss_valid_i || !is_empty;
    assign l2_write_o = !rdmiss_valid_i;
    assign l2_addr_o  = rdmiss_valid_i ? rdmiss_addr_i : head_addr;
    assign l2_data_o  = head_data;

    assert_read_all_ways_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid_o && !l2_write_o) |-> (l2_way_en_o == {WAYS{1'b1}}));
    assert_read_holds_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdmiss_valid_i && !push_ok) |=> (count == $past(count)));
    assert_pop_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l2_ready_i && !push_ok) |=> (count == $past(count)));
    assert_stall_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid_i && count == CNT_W'(DEPTH)) |-> stall_o);
endmodule

// File: tb/wtag_write_buffer_tb.sv
`timescale 1ns/1ps
module wtag_write_buffer_tb;
    localparam int DEPTH = 4;
    localparam int AW = 32, DW = 32, WAYS = 4;

    logic clk = 0, rst_n = 0;
    logic push_valid_i = 0, push_hit_i = 0, rdmiss_valid_i = 0, l2_ready_i = 0;
    logic [AW-1:0] push_addr_i = 0, rdmiss_addr_i = 0;
    logic [DW-1:0] push_data_i = 0;
    logic [1:0] push_way_i = 0;
    logic stall_o, l2_valid_o, l2_write_o;
    logic [AW-1:0] l2_addr_o;
    logic [DW-1:0] l2_data_o;
    logic [WAYS-1:0] l2_way_en_o;

    always #2 clk = ~clk;

    wtag_write_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .WAYS(WAYS)) u_dut (.*);

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic [AW-1:0] m_addr [16];
    logic [DW-1:0] m_data [16];
    logic [1:0]    m_way  [16];
    logic          m_hit  [16];
    int m_head = 0, m_cnt = 0;

    function automatic logic [3:0] exp_en(input logic hit, input logic [1:0] way, input logic rd);
        if (rd || !hit) return 4'b1111;
        return 4'b0001 << way;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // drive one cycle, compare outputs before the edge, update model at the edge
    task automatic step(input logic pv, input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                        input logic [1:0] pw, input logic ph, input logic rv,
                        input logic [AW-1:0] ra, input logic rdy);
        bit pop, push;
        @(negedge clk);
        push_valid_i = pv; push_addr_i = pa; push_data_i = pd; push_way_i = pw;
        push_hit_i = ph; rdmiss_valid_i = rv; rdmiss_addr_i = ra; l2_ready_i = rdy;
        #1;
        chk("R3 stall", 64'(stall_o), 64'(pv && m_cnt == DEPTH));
        chk("R1/R2 valid", 64'(l2_valid_o), 64'(rv || m_cnt > 0));
        if (rv) begin
            chk("R7 read addr", 64'(l2_addr_o), 64'(ra));
            chk("R7 read flag", 64'(l2_write_o), 64'd0);
            chk("R7/R8 read enables", 64'(l2_way_en_o), 64'hF);
        end else if (m_cnt > 0) begin
            chk("R2 order addr", 64'(l2_addr_o), 64'(m_addr[m_head]));
            chk("R2 order data", 64'(l2_data_o), 64'(m_data[m_head]));
            chk(m_hit[m_head] ? "R4/R5 hit enables" : "R4/R6 miss enables",
                64'(l2_way_en_o), 64'(exp_en(m_hit[m_head], m_way[m_head], 1'b0)));
        end
        pop  = rdy && !rv && m_cnt > 0;   // R9
        push = pv && m_cnt < DEPTH;       // R3
        @(posedge clk);
        if (push) begin
            m_addr[(m_head + m_cnt) % 16] = pa; m_data[(m_head + m_cnt) % 16] = pd;
            m_way[(m_head + m_cnt) % 16] = pw;  m_hit[(m_head + m_cnt) % 16] = ph;
        end
        if (pop) m_head = (m_head + 1) % 16;
        m_cnt = m_cnt + (push ? 1 : 0) - (pop ? 1 : 0);  // R10
    endtask

    always @(posedge clk) cyc++;

    initial begin
        while (!done && cyc < 100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        logic rv_hold;
        logic [AW-1:0] ra_hold;
        seed = 13;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 reset valid", 64'(l2_valid_o), 64'd0);
        chk("R1 reset stall", 64'(stall_o), 64'd0);
        rst_n = 1;
        // R5: fill with hits in every way, ready low; 5th push refused (R3)
        for (int i = 0; i < DEPTH + 1; i++)
            step(1, 32'h100 + i, 32'hA0 + i, 2'(i), 1, 0, 0, 0);
        step(1, 32'hDEAD, 32'hBAD, 0, 1, 0, 0, 0);  // R3 refused again
        // R8: read miss holds queue even with ready high
        step(0, 0, 0, 0, 0, 1, 32'h5000, 1);
        step(0, 0, 0, 0, 0, 1, 32'h5004, 1);
        // R10: push and pop together while full is refused; drain one then push+pop
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 32'h200, 32'hB0, 2, 0, 0, 0, 1);    // R6 miss entry, R10
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
        // random traffic
        rv_hold = 0; ra_hold = 0;
        for (int i = 0; i < 3000; i++) begin
            if (!rv_hold && ($urandom % 8) == 0) begin
                rv_hold = 1; ra_hold = $urandom;
            end
            begin
                logic rdy;
                rdy = ($urandom % 3) != 0;
                step(($urandom % 2) == 1, $urandom, $urandom, 2'($urandom % 4),
                     ($urandom % 2) == 1, rv_hold, ra_hold, rdy);
                if (rv_hold && rdy) rv_hold = 0;
            end
        end
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R2 drained", 64'(l2_valid_o), 64'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule